// File: doc/BRIEF.md
# Parallel NAND Flash Device-Side Bus Front End

This block is a clocked model of the device end of a parallel NAND flash bus. The host's chip-enable, command-latch, address-latch, write and read strobes arrive with no timing relation to the system clock. Each one passes through a two-flop synchronizer, and its edges are found on the synchronized copy. A write-strobe rising edge puts the bus byte into one of three places, chosen by the latch-enable inputs: the command decoder, the address cycle counter, or the data path. Each read-strobe falling edge loads the next word onto the output and steps the column counter.

A small register file stands in for the storage array. Each busy period lasts a fixed number of clocks for its operation, so the host sees a ready flag that drops for a set time after each confirm command. A write-protect input and a lock-enable input together give a global lock flag, and that flag blocks program and erase. The data bus may be 8 or 16 bits wide. Commands and addresses always come from the low byte.

Command codes on bits 7:0 are:

| Code | Meaning |
|---|---|
| 0x00 | Read setup |
| 0x30 | Read go |
| 0x80 | Program setup |
| 0x10 | Program go |
| 0x60 | Erase setup |
| 0xD0 | Erase go |

Top module: `nand_dev_front`

## Requirements
- R1: With CE low and the device ready, a WE rising edge with CLE high and ALE low latches a command. Only bits 7:0 are decoded, and in x16 mode the value of bits 15:8 does not change the result. A go code that does not follow its matching setup code starts nothing.
- R2: A WE rising edge with ALE high and CLE low is an address cycle. The address counter clears on every command and counts at most 4 address cycles. The first address cycle after a command loads the column from its low log2(DEPTH) bits. Later address cycles leave the column unchanged.
- R3: After a program setup, each WE rising edge with CLE and ALE both low writes the full-width bus word at the column. The column then advances and wraps modulo DEPTH. Program go then makes the device busy.
- R4: After a read setup, an address and read go, each RE falling edge places the word at the column on io_o and advances the column, wrapping modulo DEPTH.
- R5: io_oe_o is high only while the synchronized CE and RE are both low and the device is ready. Otherwise it is low.
- R6: rdy_o drops after a read go, program go or erase go and stays low for exactly RD_BUSY, PG_BUSY or ER_BUSY clocks. It stays driven whatever CE does. CE going high during busy does not abort the operation.
- R7: lock_o is high exactly when the synchronized lock-enable input is high and write-protect is low. With lock-enable low, lock_o stays low.
- R8: While lock_o is high, program and erase setup and go commands and program data cycles are rejected. rdy_o stays high and the stored words are unchanged.
- R9: Erase go sets every stored word to all ones.
- R10: After reset, rdy_o is high, io_oe_o and lock_o are low, io_o is zero, and every stored word is zero.
- R11: Strobe edges seen while CE is high have no effect. In particular, an RE falling edge does not advance the column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip enable, active low |
| cle_i | input | 1 | Command latch enable |
| ale_i | input | 1 | Address latch enable |
| we_ni | input | 1 | Write strobe, active low |
| re_ni | input | 1 | Read strobe, active low |
| wp_ni | input | 1 | Write protect, active low |
| lock_en_i | input | 1 | Lock feature enable |
| io_i | input | DW | Bus input (DW = 16 if X16 else 8) |
| io_o | output | DW | Bus output data |
| io_oe_o | output | 1 | Bus output enable for the pad tristate |
| rdy_o | output | 1 | Ready (high) / busy (low) |
| lock_o | output | 1 | All blocks locked |

## Verification
The bench builds the block with X16=1 and DEPTH=8, so each sweep covers the whole page and the column wrap, and the upper byte can be loaded with non-zero values during command and address cycles. Busy lengths are set to 3, 6 and 9 clocks, so all three operation types can be told apart by a busy-cycle count. With these values, program, read and erase runs over the full page finish quickly, and all four combinations of lock-enable and write-protect can be covered.

// File: rtl/nfd_pkg.sv
package nfd_pkg;
  localparam logic [7:0] CMD_RD_SETUP = 8'h00;
  localparam logic [7:0] CMD_RD_GO    = 8'h30;
  localparam logic [7:0] CMD_PG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PG_GO    = 8'h10;
  localparam logic [7:0] CMD_ER_SETUP = 8'h60;
  localparam logic [7:0] CMD_ER_GO    = 8'hD0;
  localparam int unsigned ADDR_CYCLES = 4;
  localparam int unsigned ACW = $clog2(ADDR_CYCLES + 1);

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } op_e;
endpackage

// File: rtl/nfd_sync.sv
module nfd_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff1_q, ff2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= RST;
      ff2_q <= RST;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end

  assign q_o = ff2_q;
endmodule

// File: rtl/nfd_addr.sv
module nfd_addr
  import nfd_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_evt_i,
  input  logic           addr_evt_i,
  input  logic [AW-1:0]  col_in_i,
  input  logic           inc_i,
  output logic [AW-1:0]  col_o,
  output logic [ACW-1:0] acnt_o
);
  logic [AW-1:0]  col_q;
  logic [ACW-1:0] acnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= '0;
      acnt_q <= '0;
    end else if (cmd_evt_i) begin
      acnt_q <= '0;
    end else if (addr_evt_i) begin
      if (acnt_q < ACW'(ADDR_CYCLES)) begin
        acnt_q <= acnt_q + 1'b1;
        if (acnt_q == '0) col_q <= col_in_i;
      end
    end else if (inc_i) begin
      col_q <= col_q + 1'b1;  // wraps modulo page depth
    end
  end

  assign col_o  = col_q;
  assign acnt_o = acnt_q;
endmodule

// File: rtl/nfd_mem.sv
module nfd_mem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          erase_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nfd_busy.sv
module nfd_busy #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] len_i,
  output logic          rdy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign rdy_o = (cnt_q == '0);
endmodule

// File: rtl/nand_dev_front.sv
module nand_dev_front
  import nfd_pkg::*;
#(
  parameter bit          X16     = 1'b0,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned RD_BUSY = 5,
  parameter int unsigned PG_BUSY = 20,
  parameter int unsigned ER_BUSY = 40,
  localparam int unsigned DW     = X16 ? 16 : 8,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned MAXB   = (RD_BUSY > PG_BUSY) ?
                                   ((RD_BUSY > ER_BUSY) ? RD_BUSY : ER_BUSY) :
                                   ((PG_BUSY > ER_BUSY) ? PG_BUSY : ER_BUSY),
  localparam int unsigned CW     = $clog2(MAXB + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          cle_i,
  input  logic          ale_i,
  input  logic          we_ni,
  input  logic          re_ni,
  input  logic          wp_ni,
  input  logic          lock_en_i,
  input  logic [DW-1:0] io_i,
  output logic [DW-1:0] io_o,
  output logic          io_oe_o,
  output logic          rdy_o,
  output logic          lock_o
);
  // strobe bundle: {lock_en, wp_n, re_n, we_n, ale, cle, ce_n}
  logic [6:0]    strb_s;
  logic [DW-1:0] io_s;
  logic          ce_s, cle_s, ale_s, we_s, re_s, wp_s, lock_en_s;
  logic          we_d, re_d;

  nfd_sync #(.W(7), .RST(7'b0111001)) u_strb_sync (
    .clk_i, .rst_ni,
    .d_i ({lock_en_i, wp_ni, re_ni, we_ni, ale_i, cle_i, ce_ni}),
    .q_o (strb_s)
  );

  nfd_sync #(.W(DW), .RST('0)) u_io_sync (
    .clk_i, .rst_ni, .d_i(io_i), .q_o(io_s)
  );

  assign {lock_en_s, wp_s, re_s, we_s, ale_s, cle_s, ce_s} = strb_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_d <= 1'b1;
      re_d <= 1'b1;
    end else begin
      we_d <= we_s;
      re_d <= re_s;
    end
  end

  logic evt_ok, we_rise, re_evt, cmd_evt, addr_evt, data_evt;
  assign lock_o   = lock_en_s & ~wp_s;
  assign evt_ok   = ~ce_s & rdy_o;
  assign we_rise  = we_s & ~we_d & evt_ok;
  assign re_evt   = ~re_s & re_d & evt_ok & ~we_rise;  // one edge per clock
  assign cmd_evt  = we_rise & cle_s & ~ale_s;
  assign addr_evt = we_rise & ale_s & ~cle_s;
  assign data_evt = we_rise & ~cle_s & ~ale_s;

  // command decode
  op_e           op_q, op_d;
  logic          start, erase;
  logic [CW-1:0] len;
  logic [7:0]    cmd_byte;
  assign cmd_byte = io_s[7:0];

  always_comb begin
    op_d  = op_q;
    start = 1'b0;
    erase = 1'b0;
    len   = CW'(RD_BUSY);
    if (cmd_evt) begin
      op_d = OP_IDLE;
      unique case (cmd_byte)
        CMD_RD_SETUP: op_d = OP_READ;
        CMD_RD_GO:    start = (op_q == OP_READ);
        CMD_PG_SETUP: op_d = lock_o ? OP_IDLE : OP_PROG;
        CMD_PG_GO: begin
          start = (op_q == OP_PROG) && !lock_o;
          len   = CW'(PG_BUSY);
        end
        CMD_ER_SETUP: op_d = lock_o ? OP_IDLE : OP_ERASE;
        CMD_ER_GO: begin
          start = (op_q == OP_ERASE) && !lock_o;
          erase = start;
          len   = CW'(ER_BUSY);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= OP_IDLE;
    else         op_q <= op_d;
  end

  nfd_busy #(.CW(CW)) u_busy (
    .clk_i, .rst_ni, .start_i(start), .len_i(len), .rdy_o(rdy_o)
  );

  // column counter and page store
  logic          wr_en;
  logic [AW-1:0] col_q;
  logic [ACW-1:0] acnt_q;
  logic [DW-1:0] rdata;
  assign wr_en = data_evt && (op_q == OP_PROG) && !lock_o;

  nfd_addr #(.AW(AW)) u_addr (
    .clk_i, .rst_ni,
    .cmd_evt_i (cmd_evt),
    .addr_evt_i(addr_evt),
    .col_in_i  (io_s[AW-1:0]),
    .inc_i     (wr_en | re_evt),
    .col_o     (col_q),
    .acnt_o    (acnt_q)
  );

  nfd_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .we_i   (wr_en),
    .waddr_i(col_q),
    .wdata_i(io_s),
    .erase_i(erase),
    .raddr_i(col_q),
    .rdata_o(rdata)
  );

  logic [DW-1:0] rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rd_q <= '0;
    else if (re_evt) rd_q <= rdata;
  end

  assign io_o    = rd_q;
  assign io_oe_o = ~ce_s & ~re_s & rdy_o;
endmodule

// File: rtl/nfd_checker.sv
module nfd_checker
  import nfd_pkg::*;
#(
  parameter int unsigned AW = 3
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           io_oe_o,
  input logic           rdy_o,
  input logic           lock_o,
  input logic           cmd_evt,
  input logic [7:0]     cmd_byte,
  input logic           re_evt,
  input logic           ce_s,
  input logic [AW-1:0]  col,
  input logic [ACW-1:0] acnt
);
  p_oe_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_oe_o |-> rdy_o);

  p_busy_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(cmd_evt));

  p_lock_read_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(rdy_o) && $past(lock_o)) |-> ($past(cmd_byte) == CMD_RD_GO));

  p_col_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_evt |=> (col == AW'($past(col) + 1'b1)));

  p_ce_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ce_s) |-> $stable(col));

  p_acnt_max_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acnt <= ACW'(ADDR_CYCLES));
endmodule

bind nand_dev_front nfd_checker #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .io_oe_o (io_oe_o),
  .rdy_o   (rdy_o),
  .lock_o  (lock_o),
  .cmd_evt (cmd_evt),
  .cmd_byte(cmd_byte),
  .re_evt  (re_evt),
  .ce_s    (ce_s),
  .col     (col_q),
  .acnt    (acnt_q)
);

// File: tb/sim_nand_dev_front.sv
`timescale 1ns/1ps
module sim_nand_dev_front;
  localparam int DEPTH = 8;
  localparam int RDB = 3, PGB = 6, ERB = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
  logic wp_n = 1'b1, lock_en = 1'b0;
  logic [15:0] io_in = '0;
  logic [15:0] io_out;
  logic oe, rdy, lk;

  int total = 0, bad = 0;
  logic [15:0] model [DEPTH];

  always #4 clk = ~clk;

  nand_dev_front #(.X16(1'b1), .DEPTH(DEPTH), .RD_BUSY(RDB), .PG_BUSY(PGB),
                   .ER_BUSY(ERB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .cle_i(cle), .ale_i(ale),
    .we_ni(we_n), .re_ni(re_n), .wp_ni(wp_n), .lock_en_i(lock_en),
    .io_i(io_in), .io_o(io_out), .io_oe_o(oe), .rdy_o(rdy), .lock_o(lk)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int i);
    return 16'((i + 1) * 16'h1F23) ^ 16'hA5C3;
  endfunction

  task automatic wr_cyc(input bit c, input bit a, input logic [15:0] d);
    cle = c; ale = a; io_in = d;
    tick(3); we_n = 1'b0; tick(3); we_n = 1'b1; tick(4);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    wr_cyc(1'b1, 1'b0, {8'hA5, c});  // upper byte must be ignored (R1)
  endtask

  task automatic adr(input logic [7:0] a);
    wr_cyc(1'b0, 1'b1, {8'h3C, a});
  endtask

  // issue a go command and measure the busy window
  task automatic go(input logic [7:0] c, input int exp_len, input bit drop_ce, input string req);
    int waitn = 0;
    int low = 0;
    cle = 1'b1; io_in = {8'h5A, c};
    tick(3); we_n = 1'b0; tick(3); we_n = 1'b1;
    while (rdy && waitn < 12) begin tick(1); waitn++; end
    if (!rdy) begin
      if (drop_ce) ce_n = 1'b1;
      while (!rdy && low < 200) begin tick(1); low++; end
    end
    cle = 1'b0; ce_n = 1'b0;
    tick(4);
    chk(low == exp_len, req, low, exp_len);
  endtask

  task automatic rd_word(output logic [15:0] w, output logic oe_seen);
    re_n = 1'b0; tick(5);
    w = io_out; oe_seen = oe;
    re_n = 1'b1; tick(4);
  endtask

  task automatic rd_start(input int col);
    cmd(8'h00); adr(8'(col)); go(8'h30, RDB, 1'b0, "R4 read busy");
  endtask

  task automatic rd_page(input int col, input string req);
    logic [15:0] w;
    logic o;
    rd_start(col);
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(w, o);
      chk(w == model[(col + i) % DEPTH], req, w, model[(col + i) % DEPTH]);
      chk(o == 1'b1, "R5 oe during read", o, 1);
    end
    chk(oe == 1'b0, "R5 oe low with RE high", oe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic o;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    tick(3);
    // R10 reset state
    chk(rdy == 1'b1, "R10 rdy", rdy, 1);
    chk(oe == 1'b0, "R10 oe", oe, 0);
    chk(lk == 1'b0, "R10 lock", lk, 0);
    chk(io_out == '0, "R10 io_o", io_out, 0);
    rst_n = 1'b1; ce_n = 1'b0;
    tick(4);
    rd_page(0, "R10 zero page");

    // R1 stray go without setup
    cmd(8'h55);
    go(8'h30, 0, 1'b0, "R1 go without setup");
    go(8'hD0, 0, 1'b0, "R1 erase go without setup");

    // R3 full-page program from column 0
    cmd(8'h80); adr(8'h00);
    for (int i = 0; i < DEPTH; i++) begin
      wr_cyc(1'b0, 1'b0, pat(i)); model[i] = pat(i);
    end
    go(8'h10, PGB, 1'b0, "R3 R6 program busy");
    rd_page(0, "R3 R4 readback col0");

    // R2 five address cycles: column from the first only
    cmd(8'h00);
    adr(8'h05); adr(8'h02); adr(8'h07); adr(8'h01); adr(8'h03);
    go(8'h30, RDB, 1'b0, "R2 read busy");
    for (int i = 0; i < DEPTH; i++) begin
      rd_word(w, o);
      chk(w == model[(5 + i) % DEPTH], "R2 R4 column wrap", w, model[(5 + i) % DEPTH]);
    end

    // R3 partial program wrapping past the last column
    cmd(8'h80); adr(8'h06);
    for (int i = 0; i < 3; i++) begin
      wr_cyc(1'b0, 1'b0, 16'hB000 + 16'(i)); model[(6 + i) % DEPTH] = 16'hB000 + 16'(i);
    end
    go(8'h10, PGB, 1'b0, "R3 wrap program busy");
    rd_page(3, "R3 wrap readback");

    // R11 / R5 strobes with CE high
    rd_start(0);
    rd_word(w, o);
    chk(w == model[0], "R11 first word", w, model[0]);
    ce_n = 1'b1; tick(4);
    re_n = 1'b0; tick(5);
    chk(oe == 1'b0, "R5 oe low with CE high", oe, 0);
    chk(io_out == model[0], "R11 io_o held", io_out, model[0]);
    re_n = 1'b1; tick(4);
    ce_n = 1'b0; tick(4);
    rd_word(w, o);
    chk(w == model[1], "R11 column not advanced", w, model[1]);

    // R6 CE high during program busy does not abort
    cmd(8'h80); adr(8'h02);
    wr_cyc(1'b0, 1'b0, 16'h7E57); model[2] = 16'h7E57;
    go(8'h10, PGB, 1'b1, "R6 busy with CE high");
    rd_page(0, "R6 program completed");

    // R7 lock truth table
    for (int k = 0; k < 4; k++) begin
      lock_en = k[1]; wp_n = k[0]; tick(5);
      chk(lk == (k[1] & ~k[0]), "R7 lock flag", lk, k[1] & ~k[0]);
    end

    // R8 locked program and erase rejected
    lock_en = 1'b1; wp_n = 1'b0; tick(5);
    cmd(8'h80); adr(8'h00);
    wr_cyc(1'b0, 1'b0, 16'hDEAD);
    go(8'h10, 0, 1'b0, "R8 locked program no busy");
    cmd(8'h60); adr(8'h00);
    go(8'hD0, 0, 1'b0, "R8 locked erase no busy");
    rd_page(0, "R8 page unchanged");
    lock_en = 1'b0; tick(5);

    // R9 erase
    cmd(8'h60); adr(8'h00);
    go(8'hD0, ERB, 1'b0, "R9 erase busy");
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    rd_page(0, "R9 erased page");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule